// File: doc/BRIEF.md
# Reset Exception Vector Sequencer

This block is the CPU-side sequencer that runs once a reset has been released. On a single-cycle `reset_go` indication it reads two words from the exception vector table over a word-read bus with a request/ready handshake. The first word is the starting program counter and the second is the starting stack pointer. It then clears the vector base register and sets the interrupt mask field to all ones. Finally it loads the two fetched words into the program counter and stack pointer outputs and issues a one-cycle `exec_start` pulse.

Two reset kinds are supported, selected by `reset_kind` when `reset_go` is sampled. Both follow the same sequence but read different table slots. A new `reset_go` at any point in the sequence discards the work in progress and starts again from the program-counter read, using the newly given kind.

While the sequencer is idle, the execution core may write the vector base register and the interrupt mask through a simple write port. While the sequencer is busy, the sequencer owns both registers.

Top module: `rst_vec_seq`

## Requirements
- R1: After `rst_n` is released and before any `reset_go`, the block is idle: `busy`, `bus_req` and `exec_start` are 0, `pc_q`, `sp_q` and `vbr_q` are 0, and `imask_q` is all ones.
- R2: A `reset_go` sampled high makes `busy` and `bus_req` high in the next cycle, with `bus_addr` at the program-counter slot of the sampled kind.
- R3: The program-counter slot is read first and the stack-pointer slot second, and the second address is the first plus 4. `reset_kind` = 0 (power-on) uses addresses 0x0 and 0x4. `reset_kind` = 1 (manual) uses addresses 0x8 and 0xC.
- R4: A read holds `bus_req` high with a stable `bus_addr` until the cycle in which `bus_rdy` is high. Any number of wait cycles is accepted. A read completes in a cycle where `bus_req` and `bus_rdy` are both high.
- R5: `pc_q` and `sp_q` keep their old values throughout the sequence. They take the two fetched words only when the sequence completes.
- R6: By the cycle of `exec_start`, `vbr_q` is 0x00000000 and `imask_q` is 4'b1111.
- R7: `exec_start` is high for exactly one cycle per completed sequence. This is the cycle after the final step, and the new `pc_q` and `sp_q` are already visible in it.
- R8: `busy` is high from the cycle after `reset_go` until the cycle before `exec_start`, and is low in the `exec_start` cycle. With a wait of p cycles on the first read and s cycles on the second, `busy` lasts p+s+4 cycles.
- R9: A `reset_go` during the sequence restarts it at the program-counter read of the new kind, even in a cycle where `bus_rdy` is high. The abandoned sequence produces no `exec_start` and does not affect the loaded values.
- R10: When `core_wr` is high while `busy` is 0, `vbr_q` and `imask_q` take `core_vbr` and `core_imask` in the next cycle. When `core_wr` is high while `busy` is 1, the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reset_go | input | 1 | Single-cycle indication that a reset was released; starts or restarts the sequence |
| reset_kind | input | 1 | Reset kind sampled with `reset_go`: 0 power-on, 1 manual |
| bus_req | output | 1 | Read request, held until `bus_rdy` |
| bus_addr | output | ADDR_W | Byte address of the vector slot being read |
| bus_rdy | input | 1 | Read data valid; completes the current read |
| bus_rdata | input | DATA_W | Read data |
| core_wr | input | 1 | Execution-core write of the vector base and mask registers |
| core_vbr | input | DATA_W | Vector base value for `core_wr` |
| core_imask | input | IMASK_W | Interrupt mask value for `core_wr` |
| pc_q | output | DATA_W | Program counter start value |
| sp_q | output | DATA_W | Stack pointer start value |
| vbr_q | output | DATA_W | Vector base register |
| imask_q | output | IMASK_W | Interrupt mask field of the status register |
| busy | output | 1 | Sequence in progress |
| exec_start | output | 1 | One-cycle pulse: execution may begin |

## Verification
The hardest situation to reach from the ports is a new `reset_go` that arrives in the same cycle that the bus completes a read. In that cycle, restart must win over capture. The bench's memory model uses a wait count for each slot, so it can hold ready at a known cycle. The bench then drives `reset_go` in exactly that cycle, and also in the final load cycle and in the middle of a long stack-pointer wait. The main sweep covers both reset kinds with every pairing of 0 to 3 wait cycles on each read, and checks the exact length of `busy` for each pairing.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_FPC  = 3'd1,
    ST_FSP  = 3'd2,
    ST_INIT = 3'd3,
    ST_LOAD = 3'd4
  } rvs_state_e;

  localparam int unsigned NUM_KINDS = 2;

  // True when a state issues a bus read.
  function automatic logic state_reads(input rvs_state_e st);
    return (st == ST_FPC) || (st == ST_FSP);
  endfunction

endpackage

// File: rtl/rvs_addr_gen.sv
module rvs_addr_gen #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned POR_BASE   = 0,
  parameter int unsigned MAN_BASE   = 8,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic              kind,
  input  logic              sp_slot,
  output logic [ADDR_W-1:0] addr
);
  import rvs_pkg::*;

  logic [ADDR_W-1:0] base_tbl [NUM_KINDS];

  genvar g;
  generate
    for (g = 0; g < NUM_KINDS; g++) begin : g_base
      if (g == 0) begin : g_por
        assign base_tbl[g] = ADDR_W'(POR_BASE);
      end else begin : g_man
        assign base_tbl[g] = ADDR_W'(MAN_BASE);
      end
    end
  endgenerate

  function automatic logic [ADDR_W-1:0] slot_offset(input logic second);
    return second ? ADDR_W'(WORD_BYTES) : '0;
  endfunction

  assign addr = base_tbl[kind] + slot_offset(sp_slot);

endmodule

// File: rtl/rvs_fsm.sv
module rvs_fsm (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reset_go,
  input  logic               reset_kind,
  input  logic               bus_rdy,
  output rvs_pkg::rvs_state_e state,
  output logic               kind_q,
  output logic               bus_req,
  output logic               sp_slot,
  output logic               pc_grant,
  output logic               sp_grant,
  output logic               init_step,
  output logic               load_step,
  output logic               restart,
  output logic               busy,
  output logic               exec_start
);
  import rvs_pkg::*;

  rvs_state_e state_d;
  logic       exec_q;

  assign restart   = reset_go;
  assign bus_req   = state_reads(state);
  assign sp_slot   = (state == ST_FSP);
  assign pc_grant  = (state == ST_FPC) && bus_rdy && !reset_go;
  assign sp_grant  = (state == ST_FSP) && bus_rdy && !reset_go;
  assign init_step = (state == ST_INIT) && !reset_go;
  assign load_step = (state == ST_LOAD) && !reset_go;
  assign busy      = (state != ST_IDLE);

  always_comb begin
    state_d = state;
    if (reset_go) begin
      state_d = ST_FPC;
    end else begin
      unique case (state)
        ST_FPC:  if (bus_rdy) state_d = ST_FSP;
        ST_FSP:  if (bus_rdy) state_d = ST_INIT;
        ST_INIT: state_d = ST_LOAD;
        ST_LOAD: state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      kind_q <= 1'b0;
      exec_q <= 1'b0;
    end else begin
      state  <= state_d;
      exec_q <= load_step;
      if (reset_go) kind_q <= reset_kind;
    end
  end

  assign exec_start = exec_q;

endmodule

// File: rtl/rvs_ctl_regs.sv
module rvs_ctl_regs #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IMASK_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DATA_W-1:0]  bus_rdata,
  input  logic               pc_grant,
  input  logic               sp_grant,
  input  logic               init_step,
  input  logic               load_step,
  input  logic               busy,
  input  logic               core_wr,
  input  logic [DATA_W-1:0]  core_vbr,
  input  logic [IMASK_W-1:0] core_imask,
  output logic [DATA_W-1:0]  pc_q,
  output logic [DATA_W-1:0]  sp_q,
  output logic [DATA_W-1:0]  vbr_q,
  output logic [IMASK_W-1:0] imask_q
);

  function automatic logic [IMASK_W-1:0] mask_all();
    return {IMASK_W{1'b1}};
  endfunction

  function automatic logic [DATA_W-1:0] vbr_cleared();
    return {DATA_W{1'b0}};
  endfunction

  logic [DATA_W-1:0] pc_hold;
  logic [DATA_W-1:0] sp_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_hold <= '0;
      sp_hold <= '0;
    end else begin
      if (pc_grant) pc_hold <= bus_rdata;
      if (sp_grant) sp_hold <= bus_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      sp_q <= '0;
    end else if (load_step) begin
      pc_q <= pc_hold;
      sp_q <= sp_hold;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbr_q   <= vbr_cleared();
      imask_q <= mask_all();
    end else if (init_step) begin
      vbr_q   <= vbr_cleared();
      imask_q <= mask_all();
    end else if (core_wr && !busy) begin
      vbr_q   <= core_vbr;
      imask_q <= core_imask;
    end
  end

endmodule

// File: rtl/rst_vec_seq.sv
module rst_vec_seq #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned IMASK_W    = 4,
  parameter int unsigned POR_BASE   = 0,
  parameter int unsigned MAN_BASE   = 8,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reset_go,
  input  logic               reset_kind,
  output logic               bus_req,
  output logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_rdy,
  input  logic [DATA_W-1:0]  bus_rdata,
  input  logic               core_wr,
  input  logic [DATA_W-1:0]  core_vbr,
  input  logic [IMASK_W-1:0] core_imask,
  output logic [DATA_W-1:0]  pc_q,
  output logic [DATA_W-1:0]  sp_q,
  output logic [DATA_W-1:0]  vbr_q,
  output logic [IMASK_W-1:0] imask_q,
  output logic               busy,
  output logic               exec_start
);
  import rvs_pkg::*;

  rvs_state_e state;
  logic kind_q, sp_slot;
  logic pc_grant, sp_grant, init_step, load_step, restart;

  rvs_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .reset_go   (reset_go),
    .reset_kind (reset_kind),
    .bus_rdy    (bus_rdy),
    .state      (state),
    .kind_q     (kind_q),
    .bus_req    (bus_req),
    .sp_slot    (sp_slot),
    .pc_grant   (pc_grant),
    .sp_grant   (sp_grant),
    .init_step  (init_step),
    .load_step  (load_step),
    .restart    (restart),
    .busy       (busy),
    .exec_start (exec_start)
  );

  rvs_addr_gen #(
    .ADDR_W     (ADDR_W),
    .POR_BASE   (POR_BASE),
    .MAN_BASE   (MAN_BASE),
    .WORD_BYTES (WORD_BYTES)
  ) u_addr (
    .kind    (kind_q),
    .sp_slot (sp_slot),
    .addr    (bus_addr)
  );

  rvs_ctl_regs #(
    .DATA_W  (DATA_W),
    .IMASK_W (IMASK_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rdata  (bus_rdata),
    .pc_grant   (pc_grant),
    .sp_grant   (sp_grant),
    .init_step  (init_step),
    .load_step  (load_step),
    .busy       (busy),
    .core_wr    (core_wr),
    .core_vbr   (core_vbr),
    .core_imask (core_imask),
    .pc_q       (pc_q),
    .sp_q       (sp_q),
    .vbr_q      (vbr_q),
    .imask_q    (imask_q)
  );

endmodule

// File: rtl/rvs_chk.sv
module rvs_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned IMASK_W    = 4,
  parameter int unsigned WORD_BYTES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reset_go,
  input logic               bus_req,
  input logic               bus_rdy,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               busy,
  input logic               exec_start,
  input logic [DATA_W-1:0]  pc_q,
  input logic [DATA_W-1:0]  sp_q,
  input logic [DATA_W-1:0]  vbr_q,
  input logic [IMASK_W-1:0] imask_q,
  input logic               pc_grant,
  input logic               restart
);

  // R2
  start_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_go |=> (busy && bus_req));

  // R3
  slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_grant |=> (bus_req && (bus_addr == $past(bus_addr) + ADDR_W'(WORD_BYTES))));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_rdy && !reset_go) |=> (bus_req && $stable(bus_addr)));

  // R5
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_start |-> ($stable(pc_q) && $stable(sp_q)));

  // R6
  ctl_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |-> ((vbr_q == '0) && (imask_q == '1)));

  // R7
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |=> !exec_start);

  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |-> !busy);

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && busy) |=> (bus_req && !exec_start));

endmodule

bind rst_vec_seq rvs_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .IMASK_W    (IMASK_W),
  .WORD_BYTES (WORD_BYTES)
) u_rvs_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reset_go   (reset_go),
  .bus_req    (bus_req),
  .bus_rdy    (bus_rdy),
  .bus_addr   (bus_addr),
  .busy       (busy),
  .exec_start (exec_start),
  .pc_q       (pc_q),
  .sp_q       (sp_q),
  .vbr_q      (vbr_q),
  .imask_q    (imask_q),
  .pc_grant   (pc_grant),
  .restart    (restart)
);

// File: tb/rst_vec_seq_bench.sv
module rst_vec_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reset_go = 1'b0;
  logic        reset_kind = 1'b0;
  logic        bus_req, bus_rdy;
  logic [31:0] bus_addr, bus_rdata;
  logic        core_wr = 1'b0;
  logic [31:0] core_vbr = '0;
  logic [3:0]  core_imask = '0;
  logic [31:0] pc_q, sp_q, vbr_q;
  logic [3:0]  imask_q;
  logic        busy, exec_start;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  int          wait_pc = 0, wait_sp = 0, wcnt = 0;
  logic [15:0] seed = 16'h0;
  int          ngrant = 0, nexec = 0;
  logic [31:0] gaddr [0:7];

  always #2 clk = ~clk;

  rst_vec_seq u_rst_vec_seq (
    .clk(clk), .rst_n(rst_n), .reset_go(reset_go), .reset_kind(reset_kind),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_rdy(bus_rdy), .bus_rdata(bus_rdata),
    .core_wr(core_wr), .core_vbr(core_vbr), .core_imask(core_imask),
    .pc_q(pc_q), .sp_q(sp_q), .vbr_q(vbr_q), .imask_q(imask_q),
    .busy(busy), .exec_start(exec_start)
  );

  function automatic logic [31:0] mem_word(input logic [15:0] s, input logic [31:0] a);
    return {s ^ 16'hC3A5, a[15:0] ^ 16'h0F0F};
  endfunction

  // memory model: ready after a per-slot wait count
  assign bus_rdy   = bus_req && (wcnt == (bus_addr[2] ? wait_sp : wait_pc));
  assign bus_rdata = mem_word(seed, bus_addr);

  always @(posedge clk) begin
    if (!bus_req || bus_rdy || reset_go) wcnt <= 0;
    else wcnt <= wcnt + 1;
  end

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (bus_req && bus_rdy && ngrant < 8) begin
      gaddr[ngrant] <= bus_addr;
      ngrant <= ngrant + 1;
    end
    if (exec_start) nexec <= nexec + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic pulse_rst(input logic kind);
    reset_kind = kind;
    reset_go   = 1'b1;
    @(negedge clk);
    reset_go   = 1'b0;
  endtask

  task automatic wait_exec(output int cyc, output bit busy_ok, output bit hold_ok);
    logic [31:0] pc0, sp0;
    pc0 = pc_q; sp0 = sp_q;
    cyc = 0; busy_ok = 1; hold_ok = 1;
    while (!exec_start && cyc < 200) begin
      if (!busy) busy_ok = 0;
      if (pc_q != pc0 || sp_q != sp0) hold_ok = 0;
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic run_seq(input logic kind, input int wpc, input int wsp, input logic [15:0] sd);
    logic [31:0] base;
    int cyc; bit bok, hok;
    wait_pc = wpc; wait_sp = wsp; seed = sd;
    ngrant = 0; nexec = 0;
    base = kind ? 32'h8 : 32'h0;
    pulse_rst(kind);
    chk(busy && bus_req && bus_addr == base, "R2", "first request", bus_addr, base);
    wait_exec(cyc, bok, hok);
    chk(cyc == wpc + wsp + 4, "R8", "busy length", cyc, wpc + wsp + 4);
    chk(bok, "R8", "busy held", 0, 1);
    chk(!busy, "R8", "busy low at start", busy, 0);
    chk(hok, "R5", "pc/sp held during sequence", 0, 1);
    chk(ngrant == 2, "R3", "read count", ngrant, 2);
    chk(gaddr[0] == base, "R3", "first slot", gaddr[0], base);
    chk(gaddr[1] == base + 4, "R3", "second slot", gaddr[1], base + 4);
    chk(pc_q == mem_word(sd, base), "R5", "pc loaded", pc_q, mem_word(sd, base));
    chk(sp_q == mem_word(sd, base + 4), "R5", "sp loaded", sp_q, mem_word(sd, base + 4));
    chk(vbr_q == 0, "R6", "vbr cleared", vbr_q, 0);
    chk(imask_q == 4'hF, "R6", "mask set", imask_q, 4'hF);
    @(negedge clk);
    chk(!exec_start && nexec == 1, "R7", "single start pulse", nexec, 1);
  endtask

  initial begin
    int cyc; bit bok, hok;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !bus_req && !exec_start, "R1", "idle flags", {busy, bus_req, exec_start}, 0);
    chk(pc_q == 0 && sp_q == 0 && vbr_q == 0, "R1", "pc/sp/vbr zero", pc_q | sp_q | vbr_q, 0);
    chk(imask_q == 4'hF, "R1", "mask reset", imask_q, 4'hF);

    // R10: idle write accepted
    core_wr = 1'b1; core_vbr = 32'h0000_ABCD; core_imask = 4'h3;
    @(negedge clk);
    core_wr = 1'b0;
    chk(vbr_q == 32'hABCD, "R10", "idle vbr write", vbr_q, 32'hABCD);
    chk(imask_q == 4'h3, "R10", "idle mask write", imask_q, 4'h3);

    // R10: busy write ignored (checked before the init step)
    wait_pc = 5; wait_sp = 0; seed = 16'h1111; ngrant = 0; nexec = 0;
    pulse_rst(1'b0);
    core_wr = 1'b1; core_vbr = 32'h77; core_imask = 4'h5;
    @(negedge clk);
    core_wr = 1'b0;
    chk(vbr_q == 32'hABCD && imask_q == 4'h3, "R10", "busy write ignored", vbr_q, 32'hABCD);
    chk(bus_req && bus_addr == 0, "R4", "request held in wait", bus_addr, 0);
    wait_exec(cyc, bok, hok);
    chk(vbr_q == 0 && imask_q == 4'hF, "R6", "init after core write", vbr_q, 0);
    @(negedge clk);

    // main sweep: both kinds, 0..3 wait cycles on each read
    for (int k = 0; k < 2; k++)
      for (int p = 0; p < 4; p++)
        for (int s = 0; s < 4; s++)
          run_seq(k[0], p, s, 16'(k * 16 + p * 4 + s + 3));

    // R9: restart during a long second-read wait
    wait_pc = 0; wait_sp = 6; seed = 16'h2222; ngrant = 0; nexec = 0;
    pulse_rst(1'b0);
    @(negedge clk); @(negedge clk);
    pulse_rst(1'b1);
    chk(bus_req && bus_addr == 32'h8, "R9", "restart address", bus_addr, 32'h8);
    wait_exec(cyc, bok, hok);
    chk(pc_q == mem_word(16'h2222, 32'h8), "R9", "pc after restart", pc_q, mem_word(16'h2222, 32'h8));
    chk(sp_q == mem_word(16'h2222, 32'hC), "R9", "sp after restart", sp_q, mem_word(16'h2222, 32'hC));
    chk(ngrant == 3 && gaddr[1] == 32'h8 && gaddr[2] == 32'hC, "R9", "read order", gaddr[2], 32'hC);
    @(negedge clk);
    chk(nexec == 1, "R9", "one start pulse", nexec, 1);

    // R9: restart in the same cycle as the second read's ready
    wait_pc = 0; wait_sp = 0; seed = 16'h3333; ngrant = 0; nexec = 0;
    pulse_rst(1'b0);
    chk(bus_rdy && bus_addr == 0, "R9", "setup first read", bus_addr, 0);
    @(negedge clk);
    chk(bus_rdy && bus_addr == 4, "R9", "setup second read", bus_addr, 4);
    pulse_rst(1'b1);
    chk(bus_addr == 32'h8, "R9", "restart wins over ready", bus_addr, 32'h8);
    wait_exec(cyc, bok, hok);
    chk(sp_q == mem_word(16'h3333, 32'hC), "R9", "collision sp", sp_q, mem_word(16'h3333, 32'hC));
    chk(pc_q == mem_word(16'h3333, 32'h8), "R9", "collision pc", pc_q, mem_word(16'h3333, 32'h8));
    @(negedge clk);
    chk(nexec == 1, "R9", "collision start count", nexec, 1);

    // R9: restart during the final load step
    wait_pc = 0; wait_sp = 0; seed = 16'h4444; ngrant = 0; nexec = 0;
    pulse_rst(1'b1);
    @(negedge clk); @(negedge clk); @(negedge clk);
    pulse_rst(1'b0);
    chk(!exec_start && bus_addr == 0, "R9", "no start from aborted load", exec_start, 0);
    wait_exec(cyc, bok, hok);
    chk(pc_q == mem_word(16'h4444, 32'h0), "R9", "pc after load abort", pc_q, mem_word(16'h4444, 32'h0));
    @(negedge clk);
    chk(nexec == 1, "R9", "load abort start count", nexec, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule